// File: doc/BRIEF.md
# CSR access exception prioritizer

This block decides which exception a control-and-status-register access raises in a core with hypervisor support. It looks at the current privilege level, whether the hart runs virtualized, the CSR address, whether the access writes, the two indirect-access enable bits (machine-level and hypervisor-level), the two indirect select values, and the guest external interrupt selector. From these it returns one of three verdicts: no exception, illegal instruction, or virtual instruction. CSR storage, read data and trap entry belong to other blocks.

The checks are grouped into five ordered stages. Only the first stage that reports a fault decides the verdict, and every later stage is ignored. The stages are, in order:

1. the machine-level indirect enable
2. the write-to-read-only check
3. the privilege check from address bits [9:8]
4. the hypervisor-level indirect enable
5. the indirect-select and interrupt-selector validity check

Because of this order, a virtual-instruction fault from stage 4 hides an illegal-instruction fault that stage 5 would have raised. The verdict is held in a three-state output register with states FLT_NONE, FLT_ILLEGAL and FLT_VIRTUAL. On every clock edge the register loads the merged verdict, so any state can move to any state in one cycle. Reset forces FLT_NONE. Setting parameter `OUT_REG` to 0 removes the register and makes the path purely combinational.

Top module: `csr_fault_arbiter`

## Requirements
- R1: While reset is asserted the verdict is none. With `OUT_REG`=1, the outputs show the verdict for the inputs present at the previous rising clock edge.
- R2: `fault_o` encodes the verdict as 2'b00 none, 2'b01 illegal instruction and 2'b10 virtual instruction. `illegal_o` and `virtual_o` mirror codes 01 and 10, and they are never high together.
- R3: The privilege check uses address bits [9:8] as the required level (0 user, 1 supervisor, 2 hypervisor, 3 machine). Machine mode passes every level. Non-virtual supervisor mode is illegal only for level 3. Non-virtual user mode is illegal for any level other than 0. In virtual modes, level 3 is illegal. Virtual supervisor mode raises virtual for level 2. Virtual user mode raises virtual for levels 1 and 2.
- R4: Outside machine mode, with the machine-level indirect enable at 0, an access to 0x150, 0x151, 0x250 or 0x251 is illegal.
- R5: A write to an address whose bits [11:10] are 2'b11 is illegal. A read of such an address raises nothing on that account.
- R6: In a virtual mode with the hypervisor-level indirect enable at 0, an access to 0x150 or 0x151 raises virtual.
- R7: The select value is checked only for the indirect data registers. Address 0x151 uses `vsiselect_i` in a virtual mode and `siselect_i` otherwise. Address 0x251 always uses `vsiselect_i`. A select value outside 0x70..0xFF inclusive makes the access illegal.
- R8: A guest interrupt selector is valid only when it lies in 1..`NUM_GEI` (default 5). A non-virtual access to 0x25C with an invalid selector is illegal.
- R9: A virtual-mode access to 0x15C with an invalid guest interrupt selector raises virtual.
- R10: Stages are evaluated in the order R4, R5, R3, R6, R7/R8/R9, and the first stage that faults decides the verdict. For example, a virtual supervisor access to 0x151 with the hypervisor enable at 0 and a reserved select value gives virtual.
- R11: `priv_i` encodes 0 user, 1 supervisor and 3 machine; the value 2 is treated as machine. In machine mode the virtualization input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Hart runs virtualized |
| csr_addr_i | input | 12 | Address of the accessed CSR |
| csr_wr_i | input | 1 | Access writes the CSR |
| mstateen_ind_i | input | 1 | Machine-level indirect-access enable |
| hstateen_ind_i | input | 1 | Hypervisor-level indirect-access enable |
| siselect_i | input | SEL_W | Supervisor indirect select value |
| vsiselect_i | input | SEL_W | Virtual supervisor indirect select value |
| vgein_i | input | GEI_W | Guest external interrupt selector |
| fault_o | output | 2 | Verdict code |
| illegal_o | output | 1 | Verdict is illegal instruction |
| virtual_o | output | 1 | Verdict is virtual instruction |

## Verification
The bench targets the ordering corners. One case is a virtual supervisor indirect access with the hypervisor enable off and a reserved select value. A flat priority scheme would report illegal there instead of virtual. Another is a user access to an indirect CSR with the machine enable off, where a wrong order would report virtual. The edges of the select window (0x6F, 0x70, 0xFF, 0x100) and the selector values 0, `NUM_GEI` and `NUM_GEI`+1 catch off-by-one range compares. Two more cases catch a wrong choice of select source: a virtual access to 0x151 must use `vsiselect_i`, and machine mode with `virt_i` high must behave as plain machine mode.

// File: rtl/csr_fault_pkg.sv
package csr_fault_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_ILLEGAL = 2'b01,
        FLT_VIRTUAL = 2'b10
    } flt_e;

    localparam int NUM_GROUPS = 5;

    localparam logic [11:0] ADDR_SISEL   = 12'h150;
    localparam logic [11:0] ADDR_SIREG   = 12'h151;
    localparam logic [11:0] ADDR_STOPEI  = 12'h15C;
    localparam logic [11:0] ADDR_VSISEL  = 12'h250;
    localparam logic [11:0] ADDR_VSIREG  = 12'h251;
    localparam logic [11:0] ADDR_VSTOPEI = 12'h25C;
endpackage

// File: rtl/csr_group_checks.sv
module csr_group_checks
    import csr_fault_pkg::*;
#(
    parameter int SEL_W   = 12,
    parameter int GEI_W   = 6,
    parameter int NUM_GEI = 5,
    parameter int SEL_LO  = 'h70,
    parameter int SEL_HI  = 'hFF
) (
    input  logic [1:0]            priv_i,
    input  logic                  virt_i,
    input  logic [11:0]           csr_addr_i,
    input  logic                  csr_wr_i,
    input  logic                  mstateen_ind_i,
    input  logic                  hstateen_ind_i,
    input  logic [SEL_W-1:0]      siselect_i,
    input  logic [SEL_W-1:0]      vsiselect_i,
    input  logic [GEI_W-1:0]      vgein_i,
    output logic [NUM_GROUPS-1:0] grp_ill_o,
    output logic [NUM_GROUPS-1:0] grp_vir_o
);
    localparam logic [SEL_W-1:0] SelLo  = SEL_W'(SEL_LO);
    localparam logic [SEL_W-1:0] SelHi  = SEL_W'(SEL_HI);
    localparam logic [GEI_W-1:0] GeiMax = GEI_W'(NUM_GEI);

    logic             machine;
    logic             vmode;
    logic [1:0]       req_lvl;
    logic             is_sel_pair;
    logic             is_ind;
    logic             gei_ok;
    logic [SEL_W-1:0] sireg_sel;
    logic             sireg_ok;
    logic             vsireg_ok;

    always_comb begin
        machine     = priv_i[1];
        vmode       = virt_i && !machine;
        req_lvl     = csr_addr_i[9:8];
        is_sel_pair = (csr_addr_i == ADDR_SISEL) || (csr_addr_i == ADDR_SIREG);
        is_ind      = is_sel_pair || (csr_addr_i == ADDR_VSISEL) ||
                      (csr_addr_i == ADDR_VSIREG);
        gei_ok      = (vgein_i != '0) && (vgein_i <= GeiMax);
        sireg_sel   = vmode ? vsiselect_i : siselect_i;
        sireg_ok    = (sireg_sel >= SelLo) && (sireg_sel <= SelHi);
        vsireg_ok   = (vsiselect_i >= SelLo) && (vsiselect_i <= SelHi);

        grp_ill_o = '0;
        grp_vir_o = '0;

        // stage 0: machine-level indirect enable
        grp_ill_o[0] = !machine && !mstateen_ind_i && is_ind;

        // stage 1: write to a read-only address
        grp_ill_o[1] = csr_wr_i && (csr_addr_i[11:10] == 2'b11);

        // stage 2: privilege level
        if (!machine) begin
            if (req_lvl == 2'b11) begin
                grp_ill_o[2] = 1'b1;
            end else if (vmode) begin
                grp_vir_o[2] = priv_i[0] ? (req_lvl == 2'b10) : (req_lvl != 2'b00);
            end else if (!priv_i[0]) begin
                grp_ill_o[2] = (req_lvl != 2'b00);
            end
        end

        // stage 3: hypervisor-level indirect enable
        grp_vir_o[3] = vmode && !hstateen_ind_i && is_sel_pair;

        // stage 4: indirect select and guest interrupt selector
        unique case (csr_addr_i)
            ADDR_SIREG:   grp_ill_o[4] = !sireg_ok;
            ADDR_VSIREG:  grp_ill_o[4] = !vsireg_ok;
            ADDR_STOPEI:  grp_vir_o[4] = vmode && !gei_ok;
            ADDR_VSTOPEI: grp_ill_o[4] = !vmode && !gei_ok;
            default:      ;
        endcase
    end
endmodule

// File: rtl/csr_fault_merge.sv
module csr_fault_merge
    import csr_fault_pkg::*;
(
    input  logic [NUM_GROUPS-1:0] grp_ill_i,
    input  logic [NUM_GROUPS-1:0] grp_vir_i,
    output flt_e                  verdict_o
);
    // walk from the lowest-priority stage upward so the earliest stage wins
    always_comb begin
        verdict_o = FLT_NONE;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (grp_ill_i[i]) begin
                verdict_o = FLT_ILLEGAL;
            end else if (grp_vir_i[i]) begin
                verdict_o = FLT_VIRTUAL;
            end
        end
    end
endmodule

// File: rtl/csr_fault_arbiter.sv
module csr_fault_arbiter
    import csr_fault_pkg::*;
#(
    parameter int SEL_W   = 12,
    parameter int GEI_W   = 6,
    parameter int NUM_GEI = 5,
    parameter int SEL_LO  = 'h70,
    parameter int SEL_HI  = 'hFF,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       priv_i,
    input  logic             virt_i,
    input  logic [11:0]      csr_addr_i,
    input  logic             csr_wr_i,
    input  logic             mstateen_ind_i,
    input  logic             hstateen_ind_i,
    input  logic [SEL_W-1:0] siselect_i,
    input  logic [SEL_W-1:0] vsiselect_i,
    input  logic [GEI_W-1:0] vgein_i,
    output logic [1:0]       fault_o,
    output logic             illegal_o,
    output logic             virtual_o
);
    logic [NUM_GROUPS-1:0] grp_ill;
    logic [NUM_GROUPS-1:0] grp_vir;
    flt_e                  verdict_d;
    flt_e                  flt_state;

    csr_group_checks #(
        .SEL_W(SEL_W), .GEI_W(GEI_W), .NUM_GEI(NUM_GEI),
        .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)
    ) u_checks (
        .priv_i(priv_i), .virt_i(virt_i), .csr_addr_i(csr_addr_i),
        .csr_wr_i(csr_wr_i), .mstateen_ind_i(mstateen_ind_i),
        .hstateen_ind_i(hstateen_ind_i), .siselect_i(siselect_i),
        .vsiselect_i(vsiselect_i), .vgein_i(vgein_i),
        .grp_ill_o(grp_ill), .grp_vir_o(grp_vir)
    );

    csr_fault_merge u_merge (
        .grp_ill_i(grp_ill), .grp_vir_i(grp_vir), .verdict_o(verdict_d)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flt_state <= FLT_NONE;
                else        flt_state <= verdict_d;
            end
        end else begin : g_comb
            assign flt_state = verdict_d;
        end
    endgenerate

    always_comb begin
        fault_o   = flt_state;
        illegal_o = 1'b0;
        virtual_o = 1'b0;
        unique case (flt_state)
            FLT_ILLEGAL: illegal_o = 1'b1;
            FLT_VIRTUAL: virtual_o = 1'b1;
            default:     ;
        endcase
    end

    // ---------------- assertions ----------------
    logic ind_addr;
    logic sel_pair_addr;
    logic gei_bad;
    assign sel_pair_addr = (csr_addr_i == 12'h150) || (csr_addr_i == 12'h151);
    assign ind_addr      = sel_pair_addr || (csr_addr_i == 12'h250) || (csr_addr_i == 12'h251);
    assign gei_bad       = (vgein_i == '0) || (int'(vgein_i) > NUM_GEI);

    generate
        if (OUT_REG) begin : g_chk
            // R3: non-virtual user touching any non-user level
            a_r3_user_level: assert property (@(posedge clk) disable iff (!rst_n)
                (priv_i == 2'b00 && !virt_i && csr_addr_i[9:8] != 2'b00) |=> illegal_o);
            // R4: machine enable off blocks indirect CSRs below machine mode
            a_r4_mach_enable: assert property (@(posedge clk) disable iff (!rst_n)
                (!priv_i[1] && !mstateen_ind_i && ind_addr) |=> illegal_o);
            // R6 and R10: hypervisor enable fault wins over later checks
            a_r6_virt_enable: assert property (@(posedge clk) disable iff (!rst_n)
                (!priv_i[1] && virt_i && mstateen_ind_i && !hstateen_ind_i && sel_pair_addr)
                |=> virtual_o);
            // R8: non-virtual access to the guest top-interrupt CSR with bad selector
            a_r8_vstopei: assert property (@(posedge clk) disable iff (!rst_n)
                ((priv_i[1] || (priv_i == 2'b01 && !virt_i)) && csr_addr_i == 12'h25C && gei_bad)
                |=> illegal_o);
            // R9: virtual access to the supervisor top-interrupt CSR with bad selector
            a_r9_stopei: assert property (@(posedge clk) disable iff (!rst_n)
                (!priv_i[1] && virt_i && csr_addr_i == 12'h15C && gei_bad) |=> virtual_o);
            // R2: never both verdict flags
            a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(illegal_o && virtual_o));
        end
    endgenerate
endmodule

// File: tb/csr_fault_arbiter_test.sv
module csr_fault_arbiter_test;
    localparam int SEL_W   = 12;
    localparam int GEI_W   = 6;
    localparam int NUM_GEI = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       priv = 2'b00;
    logic             virt = 1'b0;
    logic [11:0]      addr = 12'h300;
    logic             wr = 1'b0;
    logic             mst = 1'b0;
    logic             hst = 1'b0;
    logic [SEL_W-1:0] sis = '0;
    logic [SEL_W-1:0] vsis = '0;
    logic [GEI_W-1:0] vg = '0;
    logic [1:0]       fault;
    logic             ill_o;
    logic             vir_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    csr_fault_arbiter #(.SEL_W(SEL_W), .GEI_W(GEI_W), .NUM_GEI(NUM_GEI)) uut (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .virt_i(virt), .csr_addr_i(addr),
        .csr_wr_i(wr), .mstateen_ind_i(mst), .hstateen_ind_i(hst),
        .siselect_i(sis), .vsiselect_i(vsis), .vgein_i(vg),
        .fault_o(fault), .illegal_o(ill_o), .virtual_o(vir_o)
    );

    localparam logic [1:0] E_NONE = 2'b00;
    localparam logic [1:0] E_ILL  = 2'b01;
    localparam logic [1:0] E_VIR  = 2'b10;

    function automatic logic sel_in_window(input logic [SEL_W-1:0] s);
        return (s >= 12'h070) && (s <= 12'h0FF);
    endfunction

    // reference verdict built directly from the requirement text
    function automatic logic [1:0] expect_of();
        logic m, v, su;
        logic [1:0] lvl;
        logic gei_valid;
        m = (priv == 2'b11) || (priv == 2'b10);
        v = virt && !m;
        su = (priv == 2'b01);
        lvl = addr[9:8];
        gei_valid = (vg >= 1) && (vg <= NUM_GEI);
        if (!m && !mst && (addr == 12'h150 || addr == 12'h151 || addr == 12'h250 || addr == 12'h251))
            return E_ILL;
        if (wr && addr[11:10] == 2'b11) return E_ILL;
        if (!m) begin
            if (lvl == 2'd3) return E_ILL;
            if (!v && !su && lvl != 2'd0) return E_ILL;
            if (v && su && lvl == 2'd2) return E_VIR;
            if (v && !su && lvl != 2'd0) return E_VIR;
        end
        if (v && !hst && (addr == 12'h150 || addr == 12'h151)) return E_VIR;
        if (addr == 12'h151 && !sel_in_window(v ? vsis : sis)) return E_ILL;
        if (addr == 12'h251 && !sel_in_window(vsis)) return E_ILL;
        if (addr == 12'h15C && v && !gei_valid) return E_VIR;
        if (addr == 12'h25C && !v && !gei_valid) return E_ILL;
        return E_NONE;
    endfunction

    function automatic logic [11:0] pick_addr(input int k);
        case (k)
            0: return 12'h150;  1: return 12'h151;  2: return 12'h250;
            3: return 12'h251;  4: return 12'h15C;  5: return 12'h25C;
            6: return 12'hC00;  7: return 12'h300;  8: return 12'h600;
            9: return 12'h100;  10: return 12'h000; default: return 12'hF11;
        endcase
    endfunction

    task automatic set_in(input logic [1:0] p, input logic vv, input logic [11:0] a,
                          input logic w, input logic ms, input logic hs,
                          input logic [SEL_W-1:0] s, input logic [SEL_W-1:0] vs,
                          input logic [GEI_W-1:0] g);
        priv = p; virt = vv; addr = a; wr = w; mst = ms; hst = hs;
        sis = s; vsis = vs; vg = g;
    endtask

    task automatic compare(input logic [1:0] exp_v, input string tag);
        checks++;
        if (fault !== exp_v) begin
            failures++;
            $display("FAIL %s: fault=%b expected=%b (priv=%0d virt=%0d addr=%h wr=%0d ms=%0d hs=%0d sis=%h vsis=%h vg=%0d)",
                     tag, fault, exp_v, priv, virt, addr, wr, mst, hst, sis, vsis, vg);
        end
        checks++;
        if (ill_o !== (fault == E_ILL) || vir_o !== (fault == E_VIR) || (ill_o && vir_o)) begin
            failures++;
            $display("FAIL R2: flags ill=%b vir=%b expected to mirror fault=%b", ill_o, vir_o, fault);
        end
    endtask

    // inputs are set at a falling edge; the verdict is registered at the next rise
    task automatic step_check(input logic [1:0] exp_v, input string tag);
        @(negedge clk);
        compare(exp_v, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C5A1));
        // R1: reset holds verdict none though inputs would fault
        set_in(2'b00, 1'b0, 12'h300, 1'b1, 1'b0, 1'b0, '0, '0, '0);
        @(negedge clk); @(negedge clk);
        compare(E_NONE, "R1 reset");
        rst_n = 1'b1;
        step_check(E_ILL, "R1 first verdict after reset");

        // R10: virtual enable beats reserved select
        set_in(2'b01, 1'b1, 12'h151, 1'b0, 1'b1, 1'b0, 12'h080, 12'h010, 6'd1);
        step_check(E_VIR, "R10 hs-off beats reserved vsiselect");
        // R7: same with hypervisor enable on uses vsiselect
        set_in(2'b01, 1'b1, 12'h151, 1'b0, 1'b1, 1'b1, 12'h080, 12'h010, 6'd1);
        step_check(E_ILL, "R7 virtual sireg uses vsiselect");
        set_in(2'b01, 1'b1, 12'h151, 1'b0, 1'b1, 1'b1, 12'h010, 12'h080, 6'd1);
        step_check(E_NONE, "R7 virtual sireg ignores siselect");
        // R7 window edges, HS mode
        set_in(2'b01, 1'b0, 12'h151, 1'b0, 1'b1, 1'b1, 12'h06F, 12'h080, 6'd1);
        step_check(E_ILL, "R7 select 0x6F");
        set_in(2'b01, 1'b0, 12'h151, 1'b0, 1'b1, 1'b1, 12'h070, 12'h000, 6'd1);
        step_check(E_NONE, "R7 select 0x70");
        set_in(2'b01, 1'b0, 12'h151, 1'b0, 1'b1, 1'b1, 12'h0FF, 12'h000, 6'd1);
        step_check(E_NONE, "R7 select 0xFF");
        set_in(2'b01, 1'b0, 12'h151, 1'b0, 1'b1, 1'b1, 12'h100, 12'h080, 6'd1);
        step_check(E_ILL, "R7 select 0x100");
        set_in(2'b11, 1'b0, 12'h251, 1'b0, 1'b0, 1'b0, 12'h080, 12'h0FF, 6'd1);
        step_check(E_NONE, "R7 machine vsireg good select");
        // R4
        set_in(2'b01, 1'b0, 12'h250, 1'b0, 1'b0, 1'b1, 12'h080, 12'h080, 6'd1);
        step_check(E_ILL, "R4 HS vsiselect with machine enable off");
        set_in(2'b00, 1'b1, 12'h150, 1'b0, 1'b0, 1'b0, 12'h080, 12'h080, 6'd1);
        step_check(E_ILL, "R4 machine enable beats virtual faults");
        // R5
        set_in(2'b11, 1'b0, 12'hC00, 1'b1, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_ILL, "R5 write read-only");
        set_in(2'b11, 1'b0, 12'hC00, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_NONE, "R5 read read-only");
        // R3
        set_in(2'b01, 1'b1, 12'h600, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_VIR, "R3 VS hypervisor level");
        set_in(2'b01, 1'b1, 12'h300, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_ILL, "R3 VS machine level");
        set_in(2'b01, 1'b0, 12'h600, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_NONE, "R3 HS hypervisor level");
        set_in(2'b00, 1'b0, 12'h100, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_ILL, "R3 U supervisor level");
        set_in(2'b00, 1'b1, 12'h100, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_VIR, "R3 VU supervisor level");
        set_in(2'b00, 1'b1, 12'h000, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_NONE, "R3 VU user level");
        // R6
        set_in(2'b00, 1'b1, 12'h150, 1'b0, 1'b1, 1'b0, 12'h080, 12'h080, 6'd1);
        step_check(E_VIR, "R6 VU siselect hs-off");
        set_in(2'b01, 1'b1, 12'h150, 1'b0, 1'b1, 1'b0, 12'h080, 12'h080, 6'd1);
        step_check(E_VIR, "R6 VS siselect hs-off");
        // R8
        set_in(2'b11, 1'b0, 12'h25C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd0);
        step_check(E_ILL, "R8 machine vstopei selector 0");
        set_in(2'b01, 1'b0, 12'h25C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd5);
        step_check(E_NONE, "R8 HS vstopei selector max");
        set_in(2'b01, 1'b0, 12'h25C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd6);
        step_check(E_ILL, "R8 HS vstopei selector max+1");
        // R9
        set_in(2'b01, 1'b1, 12'h15C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd0);
        step_check(E_VIR, "R9 VS stopei selector 0");
        set_in(2'b01, 1'b1, 12'h15C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd1);
        step_check(E_NONE, "R9 VS stopei selector 1");
        set_in(2'b01, 1'b0, 12'h15C, 1'b0, 1'b1, 1'b1, '0, '0, 6'd0);
        step_check(E_NONE, "R9 HS stopei unaffected");
        // R11
        set_in(2'b11, 1'b1, 12'h150, 1'b0, 1'b0, 1'b0, 12'h080, 12'h010, 6'd0);
        step_check(E_NONE, "R11 machine ignores virt");
        set_in(2'b10, 1'b1, 12'h151, 1'b0, 1'b0, 1'b0, 12'h080, 12'h010, 6'd0);
        step_check(E_NONE, "R11 priv 2 acts as machine");

        // R10: exhaustive sweep of modes, enables, write and addresses
        for (int p = 0; p < 4; p++) begin
            for (int code = 0; code < 16; code++) begin
                for (int k = 0; k < 12; k++) begin
                    set_in(2'(p), code[0], pick_addr(k), code[1], code[2], code[3],
                           ($urandom % 2) ? SEL_W'(12'h070 + ($urandom % 144)) : SEL_W'($urandom),
                           ($urandom % 2) ? SEL_W'(12'h070 + ($urandom % 144)) : SEL_W'($urandom),
                           GEI_W'($urandom % 8));
                    step_check(expect_of(), "R10 sweep");
                end
            end
        end

        // random mix
        for (int n = 0; n < 2000; n++) begin
            set_in(2'($urandom), 1'($urandom), ($urandom % 3 == 0) ? 12'($urandom) : pick_addr($urandom % 12),
                   1'($urandom), 1'($urandom), 1'($urandom),
                   ($urandom % 2) ? SEL_W'(12'h06F + ($urandom % 147)) : SEL_W'($urandom),
                   ($urandom % 2) ? SEL_W'(12'h06F + ($urandom % 147)) : SEL_W'($urandom),
                   GEI_W'($urandom % 8));
            step_check(expect_of(), "R10 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule